// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment descriptors used in front of an address translator. Each entry holds two 64-bit words: an effective-segment word carrying the segment tag and a valid flag, and a virtual-segment word whose top two bits give the segment size. The remaining bits of that word are attributes that pass through unchanged. A dedicated lookup port compares an effective address against every entry in the same cycle. The comparison covers two segment granularities, 256 MB and 1 TB, and the lookup returns whether an entry matched, which entry it was, and that entry's virtual-segment word.

A single operation port takes one command per cycle. The commands install an entry from two operands, read back either word of a slot, invalidate every entry except slot 0, or invalidate the entry that an address hits. Illegal installs and out-of-range reads raise a one-cycle error pulse. Any invalidation that actually clears a valid entry raises a one-cycle request to flush the downstream translation cache. Walking page tables and checking page permissions are handled elsewhere.

Top module: `slb_array`

## Requirements
- R1: A lookup forms two keys from the address. The 256 MB key is address bits [63:28] with bit 27 set and bits [26:0] zero. The 1 TB key is address bits [63:40] with bit 27 set and all other bits zero. Bit 27 of the effective-segment word is the valid flag.
- R2: An entry hits only in two cases. Its effective-segment word equals the 256 MB key and its size field (virtual-segment bits [63:62]) is 2'b00, or it equals the 1 TB key and its size field is 2'b01.
- R3: When several entries hit, the lookup reports the lowest-numbered one together with its virtual-segment word. With no hit, lk_hit, lk_idx and lk_vsid are all zero.
- R4: An install (op_code 1) takes its slot from op_a[11:0]. It is rejected with op_err, and changes nothing, when any bit of op_a[11:0] at or above log2(NUM_ENT) is set.
- R5: An install is rejected with op_err, and changes nothing, when the size field of op_b is 2'b10 or 2'b11. When SUPPORT_1T is 0, any nonzero size field is also rejected.
- R6: A legal install stores op_a bits [63:27] as the effective-segment word, with bits [26:0] cleared, and stores op_b unchanged as the virtual-segment word.
- R7: op_code 2 reads the effective-segment word and op_code 3 reads the virtual-segment word of the slot in op_a[11:0]. Each read returns the word on rd_data. A slot at or above NUM_ENT returns zero on rd_data and pulses op_err.
- R8: Invalidate-all (op_code 4) clears the valid flag of every entry except entry 0. It pulses tlb_flush only if at least one of those flags was set.
- R9: Invalidate-by-address (op_code 5) looks up op_a. On a hit it clears the valid flag of the winning entry and pulses tlb_flush. On a miss nothing changes and no flush is raised.
- R10: Reset (synchronous, active high) clears every entry, so no lookup hits. It also drives rd_data, op_err and tlb_flush to zero.
- R11: Lookup is combinational on the current contents. An operation takes effect at the next clock edge. op_err and tlb_flush are registered single-cycle pulses, and op_codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_ea | input | 64 | Effective address to look up |
| lk_hit | output | 1 | Some entry matches lk_ea |
| lk_idx | output | log2(NUM_ENT) | Index of the winning entry |
| lk_vsid | output | 64 | Virtual-segment word of the winning entry |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 1 install, 2 read segment tag, 3 read virtual word, 4 invalidate all, 5 invalidate by address |
| op_a | input | 64 | First operand: slot/tag for install, slot for reads, address for invalidate |
| op_b | input | 64 | Second operand: virtual-segment word for install |
| rd_data | output | 64 | Registered read result |
| op_err | output | 1 | Registered pulse: illegal install or read slot |
| tlb_flush | output | 1 | Registered pulse: an invalidate cleared a valid entry |

## Verification
The bench builds the default array of eight entries with 1 TB support on. It also builds a second copy with SUPPORT_1T set to 0, and both copies share the operation bus. With eight entries, slot 8 and slot bit 11 fall just past the legal range, so both sides of the slot check are reachable. The second copy shows a 1 TB install that one configuration accepts and the other rejects. Overlapping 256 MB and 1 TB entries are placed so that priority between entries, mismatches of the size field, and the protection of entry 0 against invalidate-all all show up on the lookup port.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 27;
  localparam int SEG_S_LSB = 28;   // small (256 MB) segment tag low bit
  localparam int SEG_L_LSB = 40;   // large (1 TB) segment tag low bit
  localparam int SLOT_W    = 12;   // operand bits carrying the slot number
  localparam logic [1:0] SZ_SMALL = 2'b00;
  localparam logic [1:0] SZ_LARGE = 2'b01;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_INSTALL = 3'd1,
    OP_RD_TAG  = 3'd2,
    OP_RD_VIRT = 3'd3,
    OP_INV_ALL = 3'd4,
    OP_INV_EA  = 3'd5
  } slb_op_e;

  function automatic logic [WORD_W-1:0] key_small(input logic [WORD_W-1:0] ea);
    logic [WORD_W-1:0] k;
    k = '0;
    k[WORD_W-1:SEG_S_LSB] = ea[WORD_W-1:SEG_S_LSB];
    k[VALID_BIT] = 1'b1;
    return k;
  endfunction

  function automatic logic [WORD_W-1:0] key_large(input logic [WORD_W-1:0] ea);
    logic [WORD_W-1:0] k;
    k = '0;
    k[WORD_W-1:SEG_L_LSB] = ea[WORD_W-1:SEG_L_LSB];
    k[VALID_BIT] = 1'b1;
    return k;
  endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WORD_W-1:0]               ea,
  input  logic [NUM_ENT-1:0][WORD_W-1:0]  tag_words,
  input  logic [NUM_ENT-1:0][WORD_W-1:0]  virt_words,
  output logic                            hit,
  output logic [IDX_W-1:0]                idx
);
  logic [WORD_W-1:0]  k_small, k_large;
  logic [NUM_ENT-1:0] hv;

  assign k_small = key_small(ea);
  assign k_large = key_large(ea);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hv[g] = ((tag_words[g] == k_small) && (virt_words[g][WORD_W-1 -: 2] == SZ_SMALL)) ||
                   ((tag_words[g] == k_large) && (virt_words[g][WORD_W-1 -: 2] == SZ_LARGE));
  end

  // fixed priority: lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  logic [NUM_ENT-1:0] below_mask;
  assign below_mask = (NUM_ENT'(1) << idx) - NUM_ENT'(1);

  AST_HIT_SELECTS_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit |-> hv[idx]);                                  // R2
  AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hv == '0));                              // R2
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((hv & below_mask) == '0));                // R3
endmodule

// File: rtl/slb_opcheck.sv
module slb_opcheck
  import slb_pkg::*;
#(
  parameter int NUM_ENT    = 8,
  parameter bit SUPPORT_1T = 1'b1,
  localparam int IDX_W     = $clog2(NUM_ENT)
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              slot_ok,
  output logic              size_ok,
  output logic [IDX_W-1:0]  slot,
  output logic [WORD_W-1:0] tag_store
);
  logic [1:0] sz;

  assign slot    = op_a[IDX_W-1:0];
  assign slot_ok = (op_a[SLOT_W-1:IDX_W] == '0);
  assign sz      = op_b[WORD_W-1 -: 2];

  if (SUPPORT_1T) begin : g_large
    assign size_ok = (sz == SZ_SMALL) || (sz == SZ_LARGE);
  end else begin : g_small_only
    assign size_ok = (sz == SZ_SMALL);
  end

  assign tag_store = {op_a[WORD_W-1:VALID_BIT], {VALID_BIT{1'b0}}};
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int NUM_ENT    = 8,
  parameter bit SUPPORT_1T = 1'b1,
  localparam int IDX_W     = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       lk_ea,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [63:0]       lk_vsid,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [63:0]       op_a,
  input  logic [63:0]       op_b,
  output logic [63:0]       rd_data,
  output logic              op_err,
  output logic              tlb_flush
);
  logic [NUM_ENT-1:0][WORD_W-1:0] tag_q, virt_q;
  logic [NUM_ENT-1:0]             valid_v;

  logic              inv_hit;
  logic [IDX_W-1:0]  inv_idx;
  logic              slot_ok, size_ok;
  logic [IDX_W-1:0]  slot;
  logic [WORD_W-1:0] tag_store;
  logic              wr_legal;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_valid
    assign valid_v[g] = tag_q[g][VALID_BIT];
  end

  slb_match #(.NUM_ENT(NUM_ENT)) u_lookup (
    .clk(clk), .rst(rst), .ea(lk_ea),
    .tag_words(tag_q), .virt_words(virt_q),
    .hit(lk_hit), .idx(lk_idx)
  );

  slb_match #(.NUM_ENT(NUM_ENT)) u_inval (
    .clk(clk), .rst(rst), .ea(op_a),
    .tag_words(tag_q), .virt_words(virt_q),
    .hit(inv_hit), .idx(inv_idx)
  );

  slb_opcheck #(.NUM_ENT(NUM_ENT), .SUPPORT_1T(SUPPORT_1T)) u_check (
    .op_a(op_a), .op_b(op_b),
    .slot_ok(slot_ok), .size_ok(size_ok),
    .slot(slot), .tag_store(tag_store)
  );

  assign wr_legal = slot_ok && size_ok;
  assign lk_vsid  = lk_hit ? virt_q[lk_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q     <= '0;
      virt_q    <= '0;
      rd_data   <= '0;
      op_err    <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      op_err    <= 1'b0;
      tlb_flush <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_INSTALL: begin
            if (wr_legal) begin
              tag_q[slot]  <= tag_store;
              virt_q[slot] <= op_b;
            end else begin
              op_err <= 1'b1;
            end
          end
          OP_RD_TAG, OP_RD_VIRT: begin
            if (slot_ok) begin
              rd_data <= (op_code == OP_RD_TAG) ? tag_q[slot] : virt_q[slot];
            end else begin
              rd_data <= '0;
              op_err  <= 1'b1;
            end
          end
          OP_INV_ALL: begin
            for (int i = 1; i < NUM_ENT; i++) tag_q[i][VALID_BIT] <= 1'b0;
            tlb_flush <= |valid_v[NUM_ENT-1:1];
          end
          OP_INV_EA: begin
            if (inv_hit) begin
              tag_q[inv_idx][VALID_BIT] <= 1'b0;
              tlb_flush <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ENTRY0_KEPT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_INV_ALL) |=> $stable(tag_q[0]));          // R8
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> ($past(op_valid) &&
                   ($past(op_code) == OP_INV_ALL || $past(op_code) == OP_INV_EA))); // R11
  AST_BAD_INSTALL_ERR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_INSTALL && !wr_legal) |=> op_err);        // R5
  AST_BAD_INSTALL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_INSTALL && !wr_legal) |=> ($stable(tag_q) && $stable(virt_q))); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    op_err |-> $past(op_valid));                                          // R7
endmodule

// File: tb/test_slb_array.sv
module test_slb_array;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] lk_ea = '0;
  logic        lk_hit, n_hit;
  logic [2:0]  lk_idx, n_idx;
  logic [63:0] lk_vsid, n_vsid;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [63:0] rd_data, n_rd;
  logic        op_err, n_err, tlb_flush, n_flush;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slb_array #(.NUM_ENT(8), .SUPPORT_1T(1'b1)) i_slb_array (
    .clk(clk), .rst(rst), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_vsid(lk_vsid), .op_valid(op_valid), .op_code(op_code), .op_a(op_a),
    .op_b(op_b), .rd_data(rd_data), .op_err(op_err), .tlb_flush(tlb_flush)
  );

  slb_array #(.NUM_ENT(8), .SUPPORT_1T(1'b0)) i_slb_array_small (
    .clk(clk), .rst(rst), .lk_ea(lk_ea), .lk_hit(n_hit), .lk_idx(n_idx),
    .lk_vsid(n_vsid), .op_valid(op_valid), .op_code(op_code), .op_a(op_a),
    .op_b(op_b), .rd_data(n_rd), .op_err(n_err), .tlb_flush(n_flush)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
  endtask

  task automatic look(input string req, input logic [63:0] ea, input logic hit,
                      input logic [2:0] idx, input logic [63:0] vsid);
    lk_ea = ea;
    #1;
    chk(req, "lk_hit", {63'd0, lk_hit}, {63'd0, hit});
    chk(req, "lk_idx", {61'd0, lk_idx}, {61'd0, idx});
    chk(req, "lk_vsid", lk_vsid, vsid);
  endtask

  task automatic t_reset();
    look("R10", 64'hC000_0001_3000_0000, 1'b0, 3'd0, 64'd0);
    chk("R10", "op_err", {63'd0, op_err}, 64'd0);
    chk("R10", "tlb_flush", {63'd0, tlb_flush}, 64'd0);
    chk("R10", "rd_data", rd_data, 64'd0);
  endtask

  task automatic t_install_small();
    do_op(3'd1, 64'hC000_0001_3800_0002, 64'h0000_0000_00AB_C000);
    chk("R6", "install err", {63'd0, op_err}, 64'd0);
    look("R1", 64'hC000_0001_3ABC_DEF0, 1'b1, 3'd2, 64'h0000_0000_00AB_C000);
    look("R1", 64'hC000_0001_4000_0000, 1'b0, 3'd0, 64'd0);
    do_op(3'd2, 64'd2, 64'd0);
    chk("R6", "tag readback", rd_data, 64'hC000_0001_3800_0000);
    do_op(3'd3, 64'd2, 64'd0);
    chk("R7", "virt readback", rd_data, 64'h0000_0000_00AB_C000);
  endtask

  task automatic t_priority();
    do_op(3'd1, 64'hC000_0001_3800_0006, 64'h0000_0000_0066_6000);
    look("R3", 64'hC000_0001_3000_0010, 1'b1, 3'd2, 64'h0000_0000_00AB_C000);
    do_op(3'd5, 64'hC000_0001_3123_4567, 64'd0);
    chk("R9", "flush on hit", {63'd0, tlb_flush}, 64'd1);
    @(negedge clk);
    chk("R11", "flush one cycle", {63'd0, tlb_flush}, 64'd0);
    look("R9", 64'hC000_0001_3000_0010, 1'b1, 3'd6, 64'h0000_0000_0066_6000);
    do_op(3'd5, 64'hDEAD_0000_0000_0000, 64'd0);
    chk("R9", "no flush on miss", {63'd0, tlb_flush}, 64'd0);
    look("R9", 64'hC000_0001_3000_0010, 1'b1, 3'd6, 64'h0000_0000_0066_6000);
  endtask

  task automatic t_large();
    do_op(3'd1, 64'h0000_0A00_0800_0005, 64'h4000_0000_0000_0777);
    look("R2", 64'h0000_0A12_3456_7890, 1'b1, 3'd5, 64'h4000_0000_0000_0777);
    do_op(3'd1, 64'h5000_0001_0800_0004, 64'h4000_0000_0000_0444);
    look("R2", 64'h5000_0001_0100_0000, 1'b0, 3'd0, 64'd0);
  endtask

  task automatic t_bad_install();
    do_op(3'd1, 64'h7000_0000_0800_0008, 64'd0);
    chk("R4", "slot 8 err", {63'd0, op_err}, 64'd1);
    look("R4", 64'h7000_0000_0000_0000, 1'b0, 3'd0, 64'd0);
    do_op(3'd1, 64'h7000_0000_0800_0801, 64'd0);
    chk("R4", "slot bit11 err", {63'd0, op_err}, 64'd1);
    do_op(3'd2, 64'd1, 64'd0);
    chk("R4", "slot1 untouched", rd_data, 64'd0);
    do_op(3'd1, 64'h8000_0000_0800_0007, 64'h8000_0000_0000_0000);
    chk("R5", "size 10 err", {63'd0, op_err}, 64'd1);
    do_op(3'd1, 64'h8000_0000_0800_0007, 64'hC000_0000_0000_0000);
    chk("R5", "size 11 err", {63'd0, op_err}, 64'd1);
    look("R5", 64'h8000_0000_0000_0000, 1'b0, 3'd0, 64'd0);
    do_op(3'd1, 64'h9000_0000_0800_0007, 64'h4000_0000_0000_0999);
    chk("R5", "large ok", {63'd0, op_err}, 64'd0);
    chk("R5", "large rejected small-only", {63'd0, n_err}, 64'd1);
    look("R5", 64'h9000_0000_1234_5678, 1'b1, 3'd7, 64'h4000_0000_0000_0999);
    chk("R5", "small-only no hit", {63'd0, n_hit}, 64'd0);
    do_op(3'd2, 64'd8, 64'd0);
    chk("R7", "read range err", {63'd0, op_err}, 64'd1);
    chk("R7", "read range data", rd_data, 64'd0);
    do_op(3'd6, 64'h7000_0000_0800_0003, 64'd0);
    chk("R11", "unused code no err", {63'd0, op_err}, 64'd0);
    do_op(3'd2, 64'd3, 64'd0);
    chk("R11", "unused code no write", rd_data, 64'd0);
  endtask

  task automatic t_inv_all();
    do_op(3'd1, 64'hA000_0000_0800_0000, 64'h0000_0000_0000_0AAA);
    do_op(3'd4, 64'd0, 64'd0);
    chk("R8", "flush when cleared", {63'd0, tlb_flush}, 64'd1);
    look("R8", 64'hC000_0001_3000_0010, 1'b0, 3'd0, 64'd0);
    look("R8", 64'h0000_0A12_3456_7890, 1'b0, 3'd0, 64'd0);
    look("R8", 64'hA000_0000_0000_0000, 1'b1, 3'd0, 64'h0000_0000_0000_0AAA);
    do_op(3'd4, 64'd0, 64'd0);
    chk("R8", "no flush when none", {63'd0, tlb_flush}, 64'd0);
    do_op(3'd2, 64'd6, 64'd0);
    chk("R8", "slot6 valid cleared", rd_data, 64'hC000_0001_3000_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_install_small();
    t_priority();
    t_large();
    t_bad_install();
    t_inv_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule